// File: doc/BRIEF.md
# Coprocessor Bank Map and Start Gate

This block sits between the host-visible control registers of a graphics coprocessor and its fetch unit. It turns the 8-bit program bank number into a 24-bit physical base address, and it flags whether that base lands in work RAM or in program ROM. The mapping depends on how many ROM and RAM banks are fitted. The ROM count is clamped to 32 banks, which is a 2 MB limit. Low banks use a mirrored window that starts at byte offset 0x200000.

The block also decides whether a start request may proceed. A request is allowed at once when the instruction cache is active and the program counter lies inside the 512-byte cached window. Without a cache hit, some bank ranges are never allowed. RAM banks need the RAM-ownership bit, and all other banks need the ROM-ownership bit. The decision is captured on a start strobe and held until the next strobe. A refused start gives a one-cycle pulse that tells the status register to drop its run flag, and no execution follows.

Top module: `bank_start_ctrl`

## Requirements
- R1: After reset, `start_ok_o` and `go_clr_o` are both 0.
- R2: A start is permitted when `cache_active_i` is 1 and `cache_base_i <= pc_i < cache_base_i + 512`. The sum is taken without 16-bit wrap. This holds whatever the bank and ownership bits are.
- R3: When there is no cache hit, banks 0x60 to 0x6F and every bank from 0x74 upward are refused.
- R4: When there is no cache hit, banks 0x70 to 0x73 are permitted exactly when `ram_own_i` is 1.
- R5: When there is no cache hit, every other bank is permitted exactly when `rom_own_i` is 1.
- R6: For a ROM bank, let b = bank & 0x7F. If b >= 0x40, `phys_base_o` = P << 16, where P = b mod N when N > 1 and P = b & 1 when N <= 1. N is the effective ROM bank count.
- R7: For a ROM bank with b < 0x40, `phys_base_o` = 0x200000 + ((b mod 2N) << 16).
- R8: N is `rom_banks_i` limited to at most 32. A value of 0 is treated as 1.
- R9: For banks 0x70 to 0x73, `ram_sel_o` = 1 and `phys_base_o` = ((bank & 3) mod M) << 16. M is `ram_banks_i`, with 0 treated as 1. For every other bank, `ram_sel_o` = 0.
- R10: `start_ok_o` takes the permit result at each clock edge where `start_i` = 1. It holds its value at every edge where `start_i` = 0.
- R11: `go_clr_o` is 1 for exactly the one cycle after an edge where `start_i` = 1 and the start was refused. It is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prg_bank_i | input | 8 | Program bank number |
| pc_i | input | 16 | Program counter |
| rom_own_i | input | 1 | Coprocessor owns ROM |
| ram_own_i | input | 1 | Coprocessor owns RAM |
| cache_active_i | input | 1 | Instruction cache holds valid code |
| cache_base_i | input | 16 | Start address of the cached window |
| rom_banks_i | input | 8 | Number of fitted 64 KB ROM banks |
| ram_banks_i | input | 3 | Number of fitted 64 KB RAM banks |
| start_i | input | 1 | Start request strobe |
| phys_base_o | output | 24 | Physical base of the selected bank |
| ram_sel_o | output | 1 | Selected bank is work RAM |
| start_ok_o | output | 1 | Held result of the last start request |
| go_clr_o | output | 1 | One-cycle pulse that clears the run flag |

## Verification
Random bank numbers from 0 to 255 are combined with random ownership bits and ROM counts from 0 to 40. Together these cover the high mirror, the low mirror, the clamp and the modulo paths. They also cover every start-check class, and the expected values are computed separately in the bench.

Directed cases probe the bank boundaries 0x5F/0x60, 0x6F/0x70 and 0x73/0x74. They also probe bank 0xF0, which masks into the high ROM half and is not RAM. These cases show whether the range compares are off by one, and whether the 7-bit mask is applied before or after the RAM test.

Cache windows are tried at the first byte, at the last byte, one byte past the end, and with a base near 0xFFFF. These separate an inclusive bound from an exclusive one and a wrapped sum from an unwrapped one. Hold sequences feed refusing inputs without a strobe after a permitted start, which shows whether the latch keeps its value.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  localparam int BANK_W = 8;
  localparam int ROM_CNT_W = 7;

  typedef enum logic [1:0] {
    KIND_ROM  = 2'd0,
    KIND_RAM  = 2'd1,
    KIND_VOID = 2'd2
  } bank_kind_t;

  // Which region class a bank number belongs to for the start check
  function automatic bank_kind_t classify_bank(input logic [BANK_W-1:0] bank);
    if (bank >= 8'h74 || (bank >= 8'h60 && bank <= 8'h6F))
      return KIND_VOID;
    else if (bank >= 8'h70)
      return KIND_RAM;
    else
      return KIND_ROM;
  endfunction

  // Effective ROM bank count: zero reads as one, upper limit applied
  function automatic logic [ROM_CNT_W-1:0] rom_count_eff(input logic [7:0] cfg,
                                                         input logic [7:0] limit);
    logic [7:0] c;
    c = (cfg == 8'd0) ? 8'd1 : ((cfg > limit) ? limit : cfg);
    return c[ROM_CNT_W-1:0];
  endfunction

  // Physical ROM bank after mirroring, from the 7-bit masked bank
  function automatic logic [ROM_CNT_W-1:0] rom_phys_bank(input logic [6:0] b7,
                                                         input logic [ROM_CNT_W-1:0] n);
    logic [ROM_CNT_W-1:0] twice;
    twice = {n[ROM_CNT_W-2:0], 1'b0};
    if (b7[6])
      return (n > 7'd1) ? (b7 % n) : {6'd0, b7[0]};
    else
      return b7 % twice;
  endfunction

  // Physical RAM bank for a 2-bit RAM index and a fitted count
  function automatic logic [1:0] ram_phys_bank(input logic [1:0] idx,
                                               input logic [2:0] cfg);
    logic [2:0] n;
    logic [2:0] r;
    n = (cfg == 3'd0) ? 3'd1 : cfg;
    r = {1'b0, idx} % n;
    return r[1:0];
  endfunction

endpackage

// File: rtl/bank_map.sv
module bank_map
  import bsc_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int ROM_MAX = 32,
  parameter logic [ADDR_W-1:0] LO_WINDOW = 24'h200000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [7:0]        rom_banks_i,
  input  logic [2:0]        ram_banks_i,
  output logic [ADDR_W-1:0] base_o,
  output logic              ram_o,
  output bank_kind_t        kind_o
);
  localparam int PAGE_SH = 16;
  localparam logic [7:0] ROM_LIM = 8'(ROM_MAX);

  logic [6:0]           b7;
  logic [ROM_CNT_W-1:0] n_rom;
  logic [ROM_CNT_W-1:0] rom_pb;
  logic [1:0]           ram_pb;
  logic                 in_ram;
  logic                 rom_hi;

  assign b7     = bank_i[6:0];
  assign n_rom  = rom_count_eff(rom_banks_i, ROM_LIM);
  assign rom_pb = rom_phys_bank(b7, n_rom);
  assign ram_pb = ram_phys_bank(bank_i[1:0], ram_banks_i);
  assign in_ram = (bank_i >= 8'h70) && (bank_i <= 8'h73);
  assign rom_hi = b7[6];

  always_comb begin
    if (in_ram)
      base_o = ADDR_W'(ram_pb) << PAGE_SH;
    else if (rom_hi)
      base_o = ADDR_W'(rom_pb) << PAGE_SH;
    else
      base_o = (ADDR_W'(rom_pb) << PAGE_SH) + LO_WINDOW;
  end

  assign ram_o  = in_ram;
  assign kind_o = classify_bank(bank_i);

  // R9
  ram_base_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_o |-> (base_o < (ADDR_W'(4) << PAGE_SH)));
  // R6
  hi_rom_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_o && bank_i[6]) |-> (base_o < (ADDR_W'(ROM_MAX) << PAGE_SH)));
  // R7
  lo_rom_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_o && !bank_i[6]) |-> (base_o >= LO_WINDOW));

endmodule

// File: rtl/start_rules.sv
module start_rules
  import bsc_pkg::*;
#(
  parameter int PC_W        = 16,
  parameter int CACHE_BYTES = 512
) (
  input  logic            clk,
  input  logic            rst_n,
  input  bank_kind_t      kind_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            cache_active_i,
  input  logic [PC_W-1:0] cache_base_i,
  input  logic            rom_own_i,
  input  logic            ram_own_i,
  output logic            cache_hit_o,
  output logic            permit_o
);
  localparam int WIDE_W = PC_W + 1;

  logic [WIDE_W-1:0] pc_w;
  logic [WIDE_W-1:0] lo_w;
  logic [WIDE_W-1:0] hi_w;

  assign pc_w = {1'b0, pc_i};
  assign lo_w = {1'b0, cache_base_i};
  assign hi_w = lo_w + WIDE_W'(CACHE_BYTES);

  assign cache_hit_o = cache_active_i && (pc_w >= lo_w) && (pc_w < hi_w);

  always_comb begin
    if (cache_hit_o)
      permit_o = 1'b1;
    else begin
      unique case (kind_i)
        KIND_RAM: permit_o = ram_own_i;
        KIND_ROM: permit_o = rom_own_i;
        default:  permit_o = 1'b0;
      endcase
    end
  end

  // R2
  cache_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cache_hit_o |-> permit_o);
  // R3
  void_bank_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cache_hit_o && kind_i == KIND_VOID) |-> !permit_o);

endmodule

// File: rtl/start_hold.sv
module start_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic permit_i,
  output logic ok_o,
  output logic clr_o
);
  logic refuse_evt;

  assign refuse_evt = start_i && !permit_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ok_o  <= 1'b0;
      clr_o <= 1'b0;
    end else begin
      if (start_i)
        ok_o <= permit_i;
      clr_o <= refuse_evt;
    end
  end

  // R10
  hold_between_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(ok_o));
  // R11
  clr_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |-> $past(start_i));
  // R11
  clr_means_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |-> !ok_o);

endmodule

// File: rtl/bank_start_ctrl.sv
module bank_start_ctrl
  import bsc_pkg::*;
#(
  parameter int PC_W        = 16,
  parameter int ADDR_W      = 24,
  parameter int CACHE_BYTES = 512,
  parameter int ROM_MAX     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        prg_bank_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              rom_own_i,
  input  logic              ram_own_i,
  input  logic              cache_active_i,
  input  logic [PC_W-1:0]   cache_base_i,
  input  logic [7:0]        rom_banks_i,
  input  logic [2:0]        ram_banks_i,
  input  logic              start_i,
  output logic [ADDR_W-1:0] phys_base_o,
  output logic              ram_sel_o,
  output logic              start_ok_o,
  output logic              go_clr_o
);
  bank_kind_t kind_w;
  logic       cache_hit_w;
  logic       permit_w;

  bank_map #(.ADDR_W(ADDR_W), .ROM_MAX(ROM_MAX)) u_map (
    .clk         (clk),
    .rst_n       (rst_n),
    .bank_i      (prg_bank_i),
    .rom_banks_i (rom_banks_i),
    .ram_banks_i (ram_banks_i),
    .base_o      (phys_base_o),
    .ram_o       (ram_sel_o),
    .kind_o      (kind_w)
  );

  start_rules #(.PC_W(PC_W), .CACHE_BYTES(CACHE_BYTES)) u_rules (
    .clk            (clk),
    .rst_n          (rst_n),
    .kind_i         (kind_w),
    .pc_i           (pc_i),
    .cache_active_i (cache_active_i),
    .cache_base_i   (cache_base_i),
    .rom_own_i      (rom_own_i),
    .ram_own_i      (ram_own_i),
    .cache_hit_o    (cache_hit_w),
    .permit_o       (permit_w)
  );

  start_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .permit_i (permit_w),
    .ok_o     (start_ok_o),
    .clr_o    (go_clr_o)
  );

  // R4
  ram_bank_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cache_hit_w && ram_sel_o) |-> (permit_w == ram_own_i));
  // R5
  rom_bank_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cache_hit_w && kind_w == KIND_ROM) |-> (permit_w == rom_own_i));

endmodule

// File: tb/sim_bank_start_ctrl.sv
`timescale 1ns/1ps
module sim_bank_start_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bank = 8'd0;
  logic [15:0] pc = 16'd0;
  logic        ron = 1'b0, ran = 1'b0, cact = 1'b0;
  logic [15:0] cbase = 16'd0;
  logic [7:0]  romc = 8'd1;
  logic [2:0]  ramc = 3'd1;
  logic        strobe = 1'b0;
  logic [23:0] phys;
  logic        rsel, ok, clr;

  int checks = 0;
  int errors = 0;
  logic exp_ok = 1'b0;

  always #2.5 clk = ~clk;

  bank_start_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .prg_bank_i(bank), .pc_i(pc),
    .rom_own_i(ron), .ram_own_i(ran), .cache_active_i(cact),
    .cache_base_i(cbase), .rom_banks_i(romc), .ram_banks_i(ramc),
    .start_i(strobe), .phys_base_o(phys), .ram_sel_o(rsel),
    .start_ok_o(ok), .go_clr_o(clr)
  );

  function automatic int sub_mod(int v, int m);
    int r = v;
    while (r >= m) r = r - m;
    return r;
  endfunction

  function automatic int want_base(int bk, int rc, int mc);
    int b, n;
    if (bk >= 112 && bk <= 115) begin
      n = (mc == 0) ? 1 : mc;
      return sub_mod(bk - 112, n) * 65536;
    end
    b = bk % 128;
    n = rc;
    if (n > 32) n = 32;
    if (n == 0) n = 1;
    if (b >= 64) return ((n <= 1) ? (b % 2) : sub_mod(b, n)) * 65536;
    return sub_mod(b, 2 * n) * 65536 + 2097152;
  endfunction

  function automatic bit want_hit(bit a, int p, int cb);
    return a && (p >= cb) && (p < cb + 512);
  endfunction

  function automatic bit want_permit(int bk, int p, bit a, int cb, bit ro, bit ra);
    if (want_hit(a, p, cb)) return 1'b1;
    if ((bk >= 96 && bk <= 111) || bk >= 116) return 1'b0;
    if (bk >= 112) return ra;
    return ro;
  endfunction

  function automatic string permit_tag(int bk, int p, bit a, int cb);
    if (want_hit(a, p, cb)) return "R2";
    if ((bk >= 96 && bk <= 111) || bk >= 116) return "R3";
    if (bk >= 112) return "R4";
    return "R5";
  endfunction

  function automatic string base_tag(int bk, int rc);
    if (bk >= 112 && bk <= 115) return "R9";
    if (rc == 0 || rc > 32) return "R8";
    if ((bk % 128) >= 64) return "R6";
    return "R7";
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(int bk, int p, bit a, int cb, bit ro, bit ra,
                      int rc, int mc, bit st);
    bit perm;
    @(negedge clk);
    bank = 8'(bk); pc = 16'(p); cact = a; cbase = 16'(cb);
    ron = ro; ran = ra; romc = 8'(rc); ramc = 3'(mc); strobe = st;
    #1;
    check(base_tag(bk, rc), int'(phys), want_base(bk, rc, mc));
    check("R9", int'(rsel), (bk >= 112 && bk <= 115) ? 1 : 0);
    perm = want_permit(bk, p, a, cb, ro, ra);
    @(posedge clk);
    #1;
    if (st) begin
      exp_ok = perm;
      check(permit_tag(bk, p, a, cb), int'(ok), int'(exp_ok));
    end else
      check("R10", int'(ok), int'(exp_ok));
    check("R11", int'(clr), (st && !perm) ? 1 : 0);
    strobe = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'(ok), 0);
    check("R1", int'(clr), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // boundary banks, owners on and off
    step(8'h5F, 0, 0, 0, 1, 0, 4, 2, 1);
    step(8'h60, 0, 0, 0, 1, 1, 4, 2, 1);
    step(8'h6F, 0, 0, 0, 1, 1, 4, 2, 1);
    step(8'h70, 0, 0, 0, 0, 1, 4, 2, 1);
    step(8'h73, 0, 0, 0, 1, 0, 4, 3, 1);
    step(8'h74, 0, 0, 0, 1, 1, 4, 2, 1);
    step(8'hFF, 0, 0, 0, 1, 1, 4, 2, 1);
    step(8'hF0, 0, 0, 0, 1, 0, 5, 2, 1);
    step(8'h10, 0, 0, 0, 0, 1, 8, 2, 1);
    // ROM count clamp and zero
    step(8'h7F, 0, 0, 0, 1, 0, 40, 1, 1);
    step(8'h3F, 0, 0, 0, 1, 0, 0, 1, 1);
    step(8'h41, 0, 0, 0, 1, 0, 1, 0, 1);
    step(8'h72, 0, 0, 0, 0, 1, 2, 0, 1);
    // cache window edges
    step(8'h60, 16'h1000, 1, 16'h1000, 0, 0, 4, 2, 1);
    step(8'h80, 16'h11FF, 1, 16'h1000, 0, 0, 4, 2, 1);
    step(8'h80, 16'h1200, 1, 16'h1000, 0, 0, 4, 2, 1);
    step(8'h80, 16'hFFFF, 1, 16'hFF00, 0, 0, 4, 2, 1);
    step(8'h80, 16'h0010, 1, 16'hFF00, 0, 0, 4, 2, 1);
    step(8'h80, 16'h1000, 0, 16'h1000, 0, 0, 4, 2, 1);
    // hold: permitted start, then refusing inputs without strobe
    step(8'h10, 0, 0, 0, 1, 0, 4, 2, 1);
    step(8'h65, 0, 0, 0, 0, 0, 4, 2, 0);
    step(8'hFF, 0, 0, 0, 0, 0, 4, 2, 0);
    step(8'h65, 0, 0, 0, 0, 0, 4, 2, 1);
    step(8'h10, 0, 0, 0, 1, 1, 4, 2, 0);

    for (int i = 0; i < 1500; i++) begin
      step(int'($urandom_range(255)), int'($urandom_range(65535)),
           bit'($urandom_range(1)), int'($urandom_range(65535)),
           bit'($urandom_range(1)), bit'($urandom_range(1)),
           int'($urandom_range(40)), int'($urandom_range(7)),
           bit'($urandom_range(1)));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule